// File: doc/BRIEF.md
# Register-Machine Arithmetic Execution Stage

This block is the arithmetic execution stage of a processor with 64-bit registers and 8-byte instructions. On each cycle with `in_valid` high it decodes the 8-bit opcode and computes a new destination value. It uses the current destination register value, the source register value, the 32-bit immediate and the 16-bit offset field. One clock later it presents the result with a write enable, or it raises `illegal_op` for an encoding it cannot execute. The register file, fetch and memory access are handled elsewhere.

The block supports two operand widths. In the narrow class the operations act on the low 32 bits, and the upper word of the result is forced to zero. In the wide class the operations act on the full 64 bits, and the immediate is sign-extended before use. The supported operations are add, subtract, the bitwise operations, move, a move with sign extension, negate, three shifts and byte-order conversion. The `HOST_LITTLE` parameter sets which endian conversion reverses bytes and which only truncates. Multiply, divide and modulo codes are rejected as unsupported.

Top module: `alu_exec_unit`

## Requirements
- R1: Opcode bits 2..0 select the class: value 4 is the 32-bit class and value 7 is the 64-bit class. Any other class value is illegal. Bit 3 selects the operand: 0 takes the immediate and 1 takes the source register. Bits 7..4 hold the operation code.
- R2: The codes ADD 0x0, SUB 0x1, OR 0x4, AND 0x5, XOR 0xa and MOV 0xb (offset 0) compute dst+b, dst-b, dst|b, dst&b, dst^b and b, with wrap-around. In the 64-bit class an immediate operand is sign-extended from 32 bits. In the 32-bit class it is zero-extended.
- R3: Every 32-bit class result except byte-order conversion is computed on the low 32 bits, and bits 63..32 are written as zero.
- R4: LSH 0x6, RSH 0x7 and ARSH 0xc shift dst by b AND 63 in the 64-bit class and by b AND 31 in the 32-bit class. ARSH fills with bit 63 or bit 31 respectively.
- R5: NEG 0x8 writes -dst. It is legal only with bit 3 clear.
- R6: MOV with offset 8, 16 or 32 writes the low 8, 16 or 32 bits of the source register, sign-extended. The 32-bit class accepts only 8 and 16, extends to 32 bits and zeroes the upper word. The immediate operand is illegal for this form.
- R7: END 0xd acts on dst only, and the immediate gives the width: 16, 32 or 64. Bits above the width are zero. The 64-bit class always reverses the bytes within the width and requires bit 3 = 0. In the 32-bit class, bit 3 = 0 converts to little-endian and bit 3 = 1 converts to big-endian. With `HOST_LITTLE`=1 the little-endian conversion only truncates and the big-endian conversion reverses the bytes.
- R8: The following encodings are illegal:
  - codes 0x2, 0x3, 0x9, 0xe and 0xf;
  - NEG with the register operand;
  - a MOV offset other than 0, 8 or 16, or 32 in the 64-bit class;
  - a nonzero offset on any other code;
  - an END width other than 16, 32 or 64;
  - END in the 64-bit class with bit 3 set.
  For an illegal encoding the block sets `illegal_op`=1, `wr_en`=0 and `result`=0.
- R9: Outputs are registered and appear on the clock edge after the inputs are accepted. A cycle with `in_valid` low, and the reset state, give `wr_en`=0, `illegal_op`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation, operand select and class |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| offset | input | 16 | Offset field (sign-extend width for MOV) |
| result | output | 64 | New destination value |
| wr_en | output | 1 | Write the result to the destination |
| illegal_op | output | 1 | Encoding rejected |

## Verification
The assertions check the following on every cycle:
- the write enable and the illegal flag are never high together;
- idle cycles produce no write;
- the upper word of a 32-bit class result is zero;
- a register MOV copies the source, and a shift by zero keeps the destination;
- NEG with the register operand and a sign-extending move with the immediate are always rejected;
- a 64-bit byte swap exchanges the end bytes.

Only the bench sweep shows the exact arithmetic of each code. It covers three classes, both operand selections, all sixteen codes, five immediates, five offsets and three data patterns. The sweep also shows the masking of shift counts above the limit, the sign fill of ARSH and the truncation of the narrow swap widths.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

   localparam logic [2:0] CLS_NARROW = 3'd4;
   localparam logic [2:0] CLS_WIDE   = 3'd7;

   typedef enum logic [3:0] {
      OPC_ADD  = 4'h0,
      OPC_SUB  = 4'h1,
      OPC_OR   = 4'h4,
      OPC_AND  = 4'h5,
      OPC_LSH  = 4'h6,
      OPC_RSH  = 4'h7,
      OPC_NEG  = 4'h8,
      OPC_XOR  = 4'ha,
      OPC_MOV  = 4'hb,
      OPC_ARSH = 4'hc,
      OPC_END  = 4'hd
   } opc_e;

   typedef enum logic [1:0] {
      SHK_LEFT  = 2'd0,
      SHK_RIGHT = 2'd1,
      SHK_ARITH = 2'd2
   } shift_kind_e;

   // 0 = none/invalid, 1 = 8 or 16 bits, 2 = 16 or 32 bits, 3 = 32 or 64 bits
   typedef logic [1:0] wsel_t;

   typedef struct packed {
      logic        wide;
      logic        use_reg;
      logic [3:0]  code;
      wsel_t       sext_w;    // 1:8 2:16 3:32
      wsel_t       swap_w;    // 1:16 2:32 3:64
      logic        swap_rev;
      logic        illegal;
   } dec_t;

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
   import alu_exec_pkg::*;
#(
   parameter bit HOST_LITTLE = 1'b1,
   parameter int IMM_W       = 32,
   parameter int OFF_W       = 16
) (
   input  logic [7:0]       opcode,
   input  logic [IMM_W-1:0] imm,
   input  logic [OFF_W-1:0] offset,
   output dec_t             dec
);

   logic [2:0] cls;
   logic       cls_ok;
   logic       code_bad;
   logic       off_bad;
   logic       neg_bad;
   logic       swap_bad;

   always_comb begin
      cls          = opcode[2:0];
      cls_ok       = (cls == CLS_NARROW) || (cls == CLS_WIDE);
      dec.wide     = (cls == CLS_WIDE);
      dec.use_reg  = opcode[3];
      dec.code     = opcode[7:4];

      unique case (offset)
         OFF_W'(8):  dec.sext_w = 2'd1;
         OFF_W'(16): dec.sext_w = 2'd2;
         OFF_W'(32): dec.sext_w = dec.wide ? 2'd3 : 2'd0;
         default:    dec.sext_w = 2'd0;
      endcase

      unique case (imm)
         IMM_W'(16): dec.swap_w = 2'd1;
         IMM_W'(32): dec.swap_w = 2'd2;
         IMM_W'(64): dec.swap_w = 2'd3;
         default:    dec.swap_w = 2'd0;
      endcase

      dec.swap_rev = dec.wide || (dec.use_reg == HOST_LITTLE);

      code_bad = (dec.code == 4'h2) || (dec.code == 4'h3) || (dec.code == 4'h9)
              || (dec.code == 4'he) || (dec.code == 4'hf);
      if (dec.code == OPC_MOV)
         off_bad = (offset != '0) && ((dec.sext_w == 2'd0) || !dec.use_reg);
      else
         off_bad = (offset != '0);
      neg_bad  = (dec.code == OPC_NEG) && dec.use_reg;
      swap_bad = (dec.code == OPC_END)
              && ((dec.swap_w == 2'd0) || (dec.wide && dec.use_reg));

      dec.illegal = !cls_ok || code_bad || off_bad || neg_bad || swap_bad;
   end

endmodule

// File: rtl/alu_exec_shift.sv
module alu_exec_shift
   import alu_exec_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]         val,
   input  logic [$clog2(XLEN)-1:0] cnt,
   input  logic                    wide,
   input  shift_kind_e             kind,
   output logic [XLEN-1:0]         out
);

   localparam int HALF  = XLEN / 2;
   localparam int CNT_W = $clog2(XLEN);

   logic [HALF-1:0]  lo;
   logic [CNT_W-2:0] cnt_n;
   logic [HALF-1:0]  res_n;
   logic [XLEN-1:0]  res_w;

   always_comb begin
      lo    = val[HALF-1:0];
      cnt_n = cnt[CNT_W-2:0];
      unique case (kind)
         SHK_LEFT:  begin res_w = val << cnt;              res_n = lo << cnt_n; end
         SHK_RIGHT: begin res_w = val >> cnt;              res_n = lo >> cnt_n; end
         default:   begin res_w = $signed(val) >>> cnt;    res_n = $signed(lo) >>> cnt_n; end
      endcase
      out = wide ? res_w : {{HALF{1'b0}}, res_n};
   end

endmodule

// File: rtl/alu_exec_bswap.sv
module alu_exec_bswap #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] val,
   input  logic [1:0]      width,
   input  logic            reverse,
   output logic [XLEN-1:0] out
);

   localparam int NB = XLEN / 8;

   logic [15:0]     rev16;
   logic [31:0]     rev32;
   logic [XLEN-1:0] revx;

   for (genvar g = 0; g < 2; g++) begin : g_r16
      assign rev16[8*g +: 8] = val[8*(1-g) +: 8];
   end
   for (genvar g = 0; g < 4; g++) begin : g_r32
      assign rev32[8*g +: 8] = val[8*(3-g) +: 8];
   end
   for (genvar g = 0; g < NB; g++) begin : g_rx
      assign revx[8*g +: 8] = val[8*(NB-1-g) +: 8];
   end

   always_comb begin
      unique case (width)
         2'd1:    out = reverse ? XLEN'(rev16) : XLEN'(val[15:0]);
         2'd2:    out = reverse ? XLEN'(rev32) : XLEN'(val[31:0]);
         2'd3:    out = reverse ? revx : val;
         default: out = '0;
      endcase
   end

endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
   import alu_exec_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int IMM_W       = 32,
   parameter int OFF_W       = 16,
   parameter bit HOST_LITTLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       opcode,
   input  logic [XLEN-1:0]  dst_val,
   input  logic [XLEN-1:0]  src_val,
   input  logic [IMM_W-1:0] imm,
   input  logic [OFF_W-1:0] offset,
   output logic [XLEN-1:0]  result,
   output logic             wr_en,
   output logic             illegal_op
);

   localparam int HALF  = XLEN / 2;
   localparam int CNT_W = $clog2(XLEN);

   if (XLEN != 64)    begin : g_chk_xlen  $error("XLEN must be 64"); end
   if (IMM_W != HALF) begin : g_chk_imm   $error("IMM_W must be XLEN/2"); end
   if (OFF_W < 6)     begin : g_chk_off   $error("OFF_W too small"); end

   dec_t            dec;
   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] opb;
   logic [XLEN-1:0] sh_out;
   logic [XLEN-1:0] sw_out;
   logic [XLEN-1:0] sx_val;
   logic [XLEN-1:0] raw;
   logic [XLEN-1:0] nxt;
   shift_kind_e     sh_kind;

   alu_exec_decode #(.HOST_LITTLE(HOST_LITTLE), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_dec (
      .opcode (opcode),
      .imm    (imm),
      .offset (offset),
      .dec    (dec)
   );

   always_comb begin
      imm_ext = dec.wide ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm}
                         : {{(XLEN-IMM_W){1'b0}}, imm};
      opb     = dec.use_reg ? src_val : imm_ext;
      unique case (dec.code)
         OPC_LSH: sh_kind = SHK_LEFT;
         OPC_RSH: sh_kind = SHK_RIGHT;
         default: sh_kind = SHK_ARITH;
      endcase
   end

   alu_exec_shift #(.XLEN(XLEN)) u_shift (
      .val  (dst_val),
      .cnt  (opb[CNT_W-1:0]),
      .wide (dec.wide),
      .kind (sh_kind),
      .out  (sh_out)
   );

   alu_exec_bswap #(.XLEN(XLEN)) u_swap (
      .val     (dst_val),
      .width   (dec.swap_w),
      .reverse (dec.swap_rev),
      .out     (sw_out)
   );

   always_comb begin
      unique case (dec.sext_w)
         2'd1:    sx_val = {{(XLEN-8){src_val[7]}},   src_val[7:0]};
         2'd2:    sx_val = {{(XLEN-16){src_val[15]}}, src_val[15:0]};
         2'd3:    sx_val = {{(XLEN-32){src_val[31]}}, src_val[31:0]};
         default: sx_val = opb;
      endcase

      unique case (dec.code)
         OPC_ADD:  raw = dst_val + opb;
         OPC_SUB:  raw = dst_val - opb;
         OPC_OR:   raw = dst_val | opb;
         OPC_AND:  raw = dst_val & opb;
         OPC_XOR:  raw = dst_val ^ opb;
         OPC_NEG:  raw = -dst_val;
         OPC_MOV:  raw = sx_val;
         OPC_LSH, OPC_RSH, OPC_ARSH: raw = sh_out;
         OPC_END:  raw = sw_out;
         default:  raw = '0;
      endcase

      if (dec.wide || (dec.code == OPC_END))
         nxt = raw;
      else
         nxt = {{HALF{1'b0}}, raw[HALF-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result     <= '0;
         wr_en      <= 1'b0;
         illegal_op <= 1'b0;
      end else begin
         wr_en      <= in_valid && !dec.illegal;
         illegal_op <= in_valid && dec.illegal;
         result     <= (in_valid && !dec.illegal) ? nxt : '0;
      end
   end

   assert_write_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, illegal_op}));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!wr_en && !illegal_op && result == '0));

   assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode[2:0] == CLS_NARROW && opcode[7:4] != OPC_END)
      |=> (result[XLEN-1:HALF] == '0));

   assert_mov_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 8'hbf && offset == '0)
      |=> (wr_en && result == $past(src_val)));

   assert_shift_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 8'h67 && imm == '0 && offset == '0)
      |=> (wr_en && result == $past(dst_val)));

   assert_neg_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode[7:3] == 5'b10001)
      |=> (illegal_op && !wr_en));

   assert_sext_imm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode[7:4] == OPC_MOV && !opcode[3] && offset != '0)
      |=> illegal_op);

   assert_swap_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 8'hd7 && imm == IMM_W'(64) && offset == '0)
      |=> (result[XLEN-1:XLEN-8] == $past(dst_val[7:0])
           && result[7:0] == $past(dst_val[XLEN-1:XLEN-8])));

endmodule

// File: tb/test_alu_exec_unit.sv
module test_alu_exec_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  opcode = '0;
   logic [63:0] dst_val = '0;
   logic [63:0] src_val = '0;
   logic [31:0] imm = '0;
   logic [15:0] offset = '0;
   logic [63:0] result;
   logic        wr_en;
   logic        illegal_op;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   alu_exec_unit i_alu_exec_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset),
      .result(result), .wr_en(wr_en), .illegal_op(illegal_op)
   );

   function automatic string req_of(input logic [3:0] c, input logic [2:0] cls, input bit bad);
      if (bad) return "R8";
      if (cls != 3'd4 && cls != 3'd7) return "R1";
      case (c)
         4'h6, 4'h7, 4'hc: return "R4";
         4'h8: return "R5";
         4'hd: return "R7";
         default: return (cls == 3'd4) ? "R3" : "R2";
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] er, input bit ew, input bit ei);
      n_checks++;
      if (result !== er || wr_en !== ew || illegal_op !== ei) begin
         n_fail++;
         $display("FAIL %s op=%h imm=%h off=%0d: got res=%h we=%b ill=%b exp res=%h we=%b ill=%b",
                  req, opcode, imm, offset, result, wr_en, illegal_op, er, ew, ei);
      end
   endtask

   task automatic run_one(input logic [2:0] cls, input bit sb, input logic [3:0] c,
                          input logic [63:0] d, input logic [63:0] s,
                          input logic [31:0] k, input logic [15:0] off);
      bit          wide, bad, rev;
      logic [63:0] b, r;
      logic [31:0] d32, b32, r32;
      int          cnt, w;
      wide = (cls == 3'd7);
      b    = sb ? s : (wide ? {{32{k[31]}}, k} : {32'd0, k});
      w    = (k == 32'd16) ? 16 : (k == 32'd32) ? 32 : (k == 32'd64) ? 64 : 0;
      bad  = (cls != 3'd4 && cls != 3'd7);
      if (c == 4'h2 || c == 4'h3 || c == 4'h9 || c == 4'he || c == 4'hf) bad = 1;
      if (c == 4'hb) begin
         if (off != 0 && !(sb && (off == 8 || off == 16 || (wide && off == 32)))) bad = 1;
      end else if (off != 0) bad = 1;
      if (c == 4'h8 && sb) bad = 1;
      if (c == 4'hd && (w == 0 || (wide && sb))) bad = 1;
      r = 64'd0;
      d32 = d[31:0]; b32 = b[31:0]; r32 = 32'd0;
      if (!bad) begin
         if (c == 4'hd) begin
            rev = wide || sb;   // little-endian host
            for (int i = 0; i < w / 8; i++)
               r[8*i +: 8] = rev ? d[8*(w/8-1-i) +: 8] : d[8*i +: 8];
         end else if (wide) begin
            cnt = int'(b[5:0]);
            case (c)
               4'h0: r = d + b;
               4'h1: r = d + (~b + 64'd1);
               4'h4: r = d | b;
               4'h5: r = d & b;
               4'ha: r = d ^ b;
               4'h8: r = 64'd0 - d;
               4'h6: r = d * (64'd1 << cnt);
               4'h7: r = d / (64'd1 << cnt);
               4'hc: r = d[63] ? ~((~d) / (64'd1 << cnt)) : d / (64'd1 << cnt);
               default: r = (off == 8)  ? {{56{s[7]}}, s[7:0]}  :
                            (off == 16) ? {{48{s[15]}}, s[15:0]} :
                            (off == 32) ? {{32{s[31]}}, s[31:0]} : b;
            endcase
         end else begin
            cnt = int'(b[4:0]);
            case (c)
               4'h0: r32 = d32 + b32;
               4'h1: r32 = d32 + (~b32 + 32'd1);
               4'h4: r32 = d32 | b32;
               4'h5: r32 = d32 & b32;
               4'ha: r32 = d32 ^ b32;
               4'h8: r32 = 32'd0 - d32;
               4'h6: r32 = d32 * (32'd1 << cnt);
               4'h7: r32 = d32 / (32'd1 << cnt);
               4'hc: r32 = d32[31] ? ~((~d32) / (32'd1 << cnt)) : d32 / (32'd1 << cnt);
               default: r32 = (off == 8)  ? {{24{s[7]}}, s[7:0]} :
                              (off == 16) ? {{16{s[15]}}, s[15:0]} : b32;
            endcase
            r = {32'd0, r32};
         end
      end
      @(negedge clk);
      in_valid = 1'b1; opcode = {c, sb, cls}; dst_val = d; src_val = s; imm = k; offset = off;
      @(negedge clk);
      check(req_of(c, cls, bad), r, !bad, bad);
      in_valid = 1'b0;
   endtask

   initial begin
      logic [2:0]  cls_l [3] = '{3'd4, 3'd7, 3'd2};
      logic [31:0] imm_l [5] = '{32'd16, 32'd32, 32'd64, 32'h8000_0021, 32'hFFFF_FFF3};
      logic [15:0] off_l [5] = '{16'd0, 16'd8, 16'd16, 16'd32, 16'd4};
      logic [63:0] d_l [3] = '{64'h8123_4567_89AB_CDEF, 64'h0000_0000_F0F0_0080, 64'h7FFF_FFFF_FFFF_FFFF};
      logic [63:0] s_l [3] = '{64'h0000_0000_0000_0025, 64'hFFFF_FFFF_FFFF_FFC1, 64'h0123_4567_8000_7F85};
      repeat (3) @(negedge clk);
      check("R9", 64'd0, 1'b0, 1'b0);   // reset state
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", 64'd0, 1'b0, 1'b0);   // idle cycle after reset
      for (int ci = 0; ci < 3; ci++)
         for (int sb = 0; sb < 2; sb++)
            for (int c = 0; c < 16; c++)
               for (int ki = 0; ki < 5; ki++)
                  for (int oi = 0; oi < 5; oi++)
                     for (int di = 0; di < 3; di++)
                        run_one(cls_l[ci], sb[0], c[3:0], d_l[di], s_l[di], imm_l[ki], off_l[oi]);
      // R4 shift count masked: 64-bit LSH by 65 acts as shift by 1
      run_one(3'd7, 1'b1, 4'h6, 64'h8000_0000_0000_0003, 64'd65, 32'd0, 16'd0);
      // R4 32-bit RSH by 33 acts as shift by 1, upper bits of dst ignored
      run_one(3'd4, 1'b1, 4'h7, 64'hFFFF_FFFF_8000_0002, 64'd33, 32'd0, 16'd0);
      // R9 idle after activity
      @(negedge clk);
      check("R9", 64'd0, 1'b0, 1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (190000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog expired: got running expected finished");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule